// File: doc/BRIEF.md
# Confidence-Gated Last-Value Predictor

This block guesses the result an instruction will produce, using only its program counter. A direct-mapped result table remembers, for each indexed slot, the most recent result written back together with a partial address tag and a valid bit. A second, smaller table keeps one 2-bit saturating confidence counter per slot. The front end presents a PC on the lookup port and gets back, in the same cycle, the stored value, a hit flag and a flag that says whether the value is trusted enough to be used speculatively.

When the instruction finishes executing, the back end presents the same PC and the real result on the update port. The block compares the real result with the value it holds for that PC. It then moves the confidence counter up or down. It also decides whether the stored value is replaced. A counter at its highest state protects the stored value from a single wrong result. Both tables take an address alignment, an index width and a tag width as parameters. The defaults are 4096 result slots and 1024 counters.

Top module: `lastval_predictor`

## Requirements
- R1: After reset every lookup returns `lkp_hit` = 0 and `lkp_use` = 0. Reset clears all valid bits and all counters to 0.
- R2: A lookup hits when the result slot chosen by PC bits [ALIGN_W+VIDX_W-1:ALIGN_W] is valid and its stored tag equals PC bits [ALIGN_W+VIDX_W+TAG_W-1:ALIGN_W+VIDX_W]. The stored value is on `lkp_value` in the same cycle. With the defaults, the index is bits [13:2] and the tag is bits [21:14].
- R3: `lkp_use` is 1 only when the lookup hits and the counter chosen by PC bits [ALIGN_W+CIDX_W-1:ALIGN_W] is 2 or 3. With the defaults, the counter index is bits [11:2].
- R4: An update that misses writes the result, the tag and the valid bit into the slot. It also sets that PC's counter to 0.
- R5: An update that hits with a result equal to the stored value increments the counter, saturating at 3, and leaves the value unchanged.
- R6: An update that hits with a different result while the counter is 3 sets the counter to 2 and keeps the stored value.
- R7: An update that hits with a different result while the counter is 0, 1 or 2 replaces the stored value. It decrements the counter, saturating at 0.
- R8: An update takes effect at the next rising clock edge. A lookup in the same cycle sees the state from before the update.
- R9: While `upd_en` is 0, the values on `upd_pc` and `upd_result` change no state.
- R10: An update from a PC with a different tag but the same result index replaces the slot. The earlier PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_pc | input | PC_W | PC presented for prediction |
| lkp_hit | output | 1 | A valid slot with a matching tag was found |
| lkp_use | output | 1 | Hit and the confidence is high enough to use the value |
| lkp_value | output | DATA_W | Stored result for the looked-up PC |
| upd_en | input | 1 | Update strobe for one cycle |
| upd_pc | input | PC_W | PC of the completed instruction |
| upd_result | input | DATA_W | Result the instruction actually produced |

## Verification
On every cycle, the assertions check that a trusted prediction always implies a hit. They also check what the update port leaves behind for the same PC on the next cycle: a freshly allocated value that is not trusted, an unchanged value after agreement, a value that a saturated counter protected and that is still trusted, and a hit in every case. The bench's scenarios cover what the assertions cannot see on their own. These are the climb of the counter through each state, the floor at 0 after a wrong result, same-cycle ordering between lookup and update, updates that are ignored while disabled, and two PCs contending for one result slot.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  typedef logic [1:0] conf_t;

  localparam conf_t CONF_ZERO    = 2'd0;
  localparam conf_t CONF_TOP     = 2'd3;
  localparam conf_t CONF_USE_MIN = 2'd2;

  typedef enum logic [1:0] {
    UPD_IDLE,
    UPD_ALLOC,
    UPD_AGREE,
    UPD_DISAGREE
  } upd_kind_e;

  function automatic conf_t conf_up(input conf_t c);
    conf_up = (c == CONF_TOP) ? c : conf_t'(c + 2'd1);
  endfunction

  function automatic conf_t conf_down(input conf_t c);
    conf_down = (c == CONF_ZERO) ? c : conf_t'(c - 2'd1);
  endfunction

  function automatic logic conf_usable(input conf_t c);
    conf_usable = (c >= CONF_USE_MIN);
  endfunction

endpackage

// File: rtl/lvp_value_table.sv
module lvp_value_table #(
  parameter int ENTRIES = 4096,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port A (lookup)
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [TAG_W-1:0]  ra_tag,
  output logic              ra_hit,
  output logic [DATA_W-1:0] ra_data,
  // read port B (update compare)
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [TAG_W-1:0]  rb_tag,
  output logic              rb_hit,
  output logic [DATA_W-1:0] rb_data,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  // valid bits: next state
  always_comb begin
    valid_d = valid_q;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  // valid bits: register, cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // payload storage: no reset, write enable only
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  // combinational read ports
  always_comb begin
    ra_hit  = valid_q[ra_idx] && (tag_q[ra_idx] == ra_tag);
    ra_data = data_q[ra_idx];
    rb_hit  = valid_q[rb_idx] && (tag_q[rb_idx] == rb_tag);
    rb_data = data_q[rb_idx];
  end

endmodule

// File: rtl/lvp_conf_table.sv
module lvp_conf_table
  import lvp_pkg::*;
#(
  parameter int ENTRIES = 1024,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output conf_t            ra_conf,
  input  logic [IDX_W-1:0] rb_idx,
  output conf_t            rb_conf,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  conf_t            wr_conf
);

  conf_t conf_q [ENTRIES];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
      logic  sel;
      conf_t nxt;

      always_comb begin
        sel = wr_en && (wr_idx == IDX_W'(g));
        nxt = sel ? wr_conf : conf_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          conf_q[g] <= CONF_ZERO;
        end else begin
          conf_q[g] <= nxt;
        end
      end
    end
  endgenerate

  always_comb begin
    ra_conf = conf_q[ra_idx];
    rb_conf = conf_q[rb_idx];
  end

endmodule

// File: rtl/lvp_update_ctrl.sv
module lvp_update_ctrl
  import lvp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              upd_en,
  input  logic              hit,
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] actual,
  input  conf_t             conf_now,
  output upd_kind_e         kind,
  output logic              val_wr,
  output logic              conf_wr,
  output conf_t             conf_next
);

  // classify the update
  always_comb begin
    if (!upd_en) begin
      kind = UPD_IDLE;
    end else if (!hit) begin
      kind = UPD_ALLOC;
    end else if (stored == actual) begin
      kind = UPD_AGREE;
    end else begin
      kind = UPD_DISAGREE;
    end
  end

  // derive the table writes
  always_comb begin
    val_wr    = 1'b0;
    conf_wr   = 1'b0;
    conf_next = conf_now;
    unique case (kind)
      UPD_IDLE: begin
        val_wr  = 1'b0;
        conf_wr = 1'b0;
      end
      UPD_ALLOC: begin
        val_wr    = 1'b1;
        conf_wr   = 1'b1;
        conf_next = CONF_ZERO;
      end
      UPD_AGREE: begin
        val_wr    = 1'b0;
        conf_wr   = 1'b1;
        conf_next = conf_up(conf_now);
      end
      UPD_DISAGREE: begin
        val_wr    = (conf_now != CONF_TOP);
        conf_wr   = 1'b1;
        conf_next = conf_down(conf_now);
      end
      default: begin
        val_wr  = 1'b0;
        conf_wr = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lastval_predictor.sv
module lastval_predictor
  import lvp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int DATA_W       = 64,
  parameter int VAL_ENTRIES  = 4096,
  parameter int CONF_ENTRIES = 1024,
  parameter int TAG_W        = 8,
  parameter int ALIGN_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lkp_pc,
  output logic              lkp_hit,
  output logic              lkp_use,
  output logic [DATA_W-1:0] lkp_value,
  input  logic              upd_en,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [DATA_W-1:0] upd_result
);

  localparam int VIDX_W  = $clog2(VAL_ENTRIES);
  localparam int CIDX_W  = $clog2(CONF_ENTRIES);
  localparam int VIDX_LO = ALIGN_W;
  localparam int TAG_LO  = ALIGN_W + VIDX_W;
  localparam int CIDX_LO = ALIGN_W;

  // address slicing
  logic [VIDX_W-1:0] lkp_vidx, upd_vidx;
  logic [TAG_W-1:0]  lkp_tag,  upd_tag;
  logic [CIDX_W-1:0] lkp_cidx, upd_cidx;

  always_comb begin
    lkp_vidx = lkp_pc[VIDX_LO +: VIDX_W];
    lkp_tag  = lkp_pc[TAG_LO  +: TAG_W];
    lkp_cidx = lkp_pc[CIDX_LO +: CIDX_W];
    upd_vidx = upd_pc[VIDX_LO +: VIDX_W];
    upd_tag  = upd_pc[TAG_LO  +: TAG_W];
    upd_cidx = upd_pc[CIDX_LO +: CIDX_W];
  end

  logic              lkp_hit_w;
  logic [DATA_W-1:0] lkp_data_w;
  logic              upd_hit_w;
  logic [DATA_W-1:0] upd_old_w;
  conf_t             lkp_conf_w;
  conf_t             upd_conf_w;
  upd_kind_e         upd_kind_w;
  logic              val_wr_w;
  logic              conf_wr_w;
  conf_t             conf_next_w;

  lvp_value_table #(
    .ENTRIES (VAL_ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) u_vtab (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (lkp_vidx),
    .ra_tag  (lkp_tag),
    .ra_hit  (lkp_hit_w),
    .ra_data (lkp_data_w),
    .rb_idx  (upd_vidx),
    .rb_tag  (upd_tag),
    .rb_hit  (upd_hit_w),
    .rb_data (upd_old_w),
    .wr_en   (val_wr_w),
    .wr_idx  (upd_vidx),
    .wr_tag  (upd_tag),
    .wr_data (upd_result)
  );

  lvp_conf_table #(
    .ENTRIES (CONF_ENTRIES)
  ) u_ctab (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (lkp_cidx),
    .ra_conf (lkp_conf_w),
    .rb_idx  (upd_cidx),
    .rb_conf (upd_conf_w),
    .wr_en   (conf_wr_w),
    .wr_idx  (upd_cidx),
    .wr_conf (conf_next_w)
  );

  lvp_update_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .upd_en    (upd_en),
    .hit       (upd_hit_w),
    .stored    (upd_old_w),
    .actual    (upd_result),
    .conf_now  (upd_conf_w),
    .kind      (upd_kind_w),
    .val_wr    (val_wr_w),
    .conf_wr   (conf_wr_w),
    .conf_next (conf_next_w)
  );

  always_comb begin
    lkp_hit   = lkp_hit_w;
    lkp_value = lkp_data_w;
    lkp_use   = lkp_hit_w && conf_usable(lkp_conf_w);
  end

endmodule

// File: rtl/lastval_predictor_chk.sv
module lastval_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   lkp_pc,
  input logic              lkp_hit,
  input logic              lkp_use,
  input logic [DATA_W-1:0] lkp_value,
  input logic              upd_en,
  input logic [PC_W-1:0]   upd_pc,
  input logic [DATA_W-1:0] upd_result,
  input logic              upd_hit,
  input logic [DATA_W-1:0] upd_old,
  input logic [1:0]        upd_conf
);

  // R3: a trusted prediction is always a hit
  a_r3_use_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_use |-> lkp_hit);

  // R4: a missing update leaves a fresh, untrusted copy of the result
  a_r4_alloc_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_en && !upd_hit) && (lkp_pc == $past(upd_pc)))
      |-> (lkp_hit && !lkp_use && (lkp_value == $past(upd_result))));

  // R5: agreement keeps the stored value
  a_r5_agree_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_en && upd_hit && (upd_old == upd_result)) && (lkp_pc == $past(upd_pc)))
      |-> (lkp_hit && (lkp_value == $past(upd_old))));

  // R6: a saturated counter shields the value and stays trusted
  a_r6_top_shields: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_en && upd_hit && (upd_conf == 2'd3) && (upd_old != upd_result))
       && (lkp_pc == $past(upd_pc)))
      |-> (lkp_hit && lkp_use && (lkp_value == $past(upd_old))));

  // R7: a wrong result below the top state is stored and not trusted
  a_r7_replace_untrusted: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_en && upd_hit && (upd_conf != 2'd3) && (upd_old != upd_result))
       && (lkp_pc == $past(upd_pc)))
      |-> (lkp_hit && !lkp_use && (lkp_value == $past(upd_result))));

endmodule

bind lastval_predictor lastval_predictor_chk #(
  .PC_W   (PC_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lkp_pc     (lkp_pc),
  .lkp_hit    (lkp_hit),
  .lkp_use    (lkp_use),
  .lkp_value  (lkp_value),
  .upd_en     (upd_en),
  .upd_pc     (upd_pc),
  .upd_result (upd_result),
  .upd_hit    (upd_hit_w),
  .upd_old    (upd_old_w),
  .upd_conf   (upd_conf_w)
);

// File: tb/lastval_predictor_test.sv
module lastval_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 32;
  localparam int DATA_W     = 64;

  logic              clk;
  logic              rst_n;
  logic [PC_W-1:0]   lkp_pc;
  logic              lkp_hit;
  logic              lkp_use;
  logic [DATA_W-1:0] lkp_value;
  logic              upd_en;
  logic [PC_W-1:0]   upd_pc;
  logic [DATA_W-1:0] upd_result;

  int n_vec;
  int n_bad;
  bit done;

  lastval_predictor uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .lkp_pc     (lkp_pc),
    .lkp_hit    (lkp_hit),
    .lkp_use    (lkp_use),
    .lkp_value  (lkp_value),
    .upd_en     (upd_en),
    .upd_pc     (upd_pc),
    .upd_result (upd_result)
  );

  // A and C share result slot and counter (C differs in tag bit 14); B is apart
  localparam logic [PC_W-1:0]   PC_A = 32'h0000_1230;
  localparam logic [PC_W-1:0]   PC_B = 32'h0000_4560;
  localparam logic [PC_W-1:0]   PC_C = 32'h0000_5230;
  localparam logic [DATA_W-1:0] V1 = 64'hDEAD_BEEF_0000_0001;
  localparam logic [DATA_W-1:0] V2 = 64'hDEAD_BEEF_0000_0002;
  localparam logic [DATA_W-1:0] W1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [DATA_W-1:0] W2 = 64'hFEDC_BA98_7654_3210;
  localparam logic [DATA_W-1:0] X1 = 64'h5555_AAAA_5555_AAAA;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  // compare the lookup port; called while inputs are stable, away from edges
  task automatic expect_lookup(input logic [PC_W-1:0] pc, input logic e_hit,
                               input logic e_use, input logic chk_val,
                               input logic [DATA_W-1:0] e_val, input string req);
    lkp_pc = pc;
    #1;
    n_vec++;
    if (lkp_hit !== e_hit || lkp_use !== e_use || (chk_val && lkp_value !== e_val)) begin
      n_bad++;
      $display("FAIL %s pc=%h: actual hit=%b use=%b val=%h expected hit=%b use=%b val=%h",
               req, pc, lkp_hit, lkp_use, lkp_value, e_hit, e_use, e_val);
    end
  endtask

  // one update cycle; returns at the following falling edge
  task automatic do_update(input logic [PC_W-1:0] pc, input logic [DATA_W-1:0] res);
    @(negedge clk);
    upd_en     = 1'b1;
    upd_pc     = pc;
    upd_result = res;
    @(negedge clk);
    upd_en     = 1'b0;
  endtask

  task automatic t_reset();
    expect_lookup(PC_A, 1'b0, 1'b0, 1'b0, '0, "R1");
    expect_lookup(PC_B, 1'b0, 1'b0, 1'b0, '0, "R1");
    expect_lookup(PC_C, 1'b0, 1'b0, 1'b0, '0, "R1");
  endtask

  task automatic t_alloc();
    do_update(PC_A, V1);
    expect_lookup(PC_A, 1'b1, 1'b0, 1'b1, V1, "R4");  // counter starts at 0
    expect_lookup(PC_B, 1'b0, 1'b0, 1'b0, '0, "R2");  // other slot untouched
  endtask

  task automatic t_train();
    do_update(PC_A, V1);                               // 0 -> 1
    expect_lookup(PC_A, 1'b1, 1'b0, 1'b1, V1, "R5");
    do_update(PC_A, V1);                               // 1 -> 2
    expect_lookup(PC_A, 1'b1, 1'b1, 1'b1, V1, "R3");
    do_update(PC_A, V1);                               // 2 -> 3
    do_update(PC_A, V1);                               // stays 3
    expect_lookup(PC_A, 1'b1, 1'b1, 1'b1, V1, "R5");
  endtask

  task automatic t_sticky();
    do_update(PC_A, V2);                               // at 3: keep V1, 3 -> 2
    expect_lookup(PC_A, 1'b1, 1'b1, 1'b1, V1, "R6");
    do_update(PC_A, V2);                               // at 2: replace, 2 -> 1
    expect_lookup(PC_A, 1'b1, 1'b0, 1'b1, V2, "R7");
  endtask

  task automatic t_floor();
    do_update(PC_B, W1);                               // alloc, 0
    do_update(PC_B, W2);                               // wrong at 0: replace, stays 0
    expect_lookup(PC_B, 1'b1, 1'b0, 1'b1, W2, "R7");
    do_update(PC_B, W2);                               // 0 -> 1, still untrusted
    expect_lookup(PC_B, 1'b1, 1'b0, 1'b1, W2, "R7");
  endtask

  task automatic t_ignore();
    @(negedge clk);
    upd_en     = 1'b0;
    upd_pc     = PC_B;
    upd_result = X1;
    @(negedge clk);
    upd_pc     = PC_C;
    @(negedge clk);
    expect_lookup(PC_B, 1'b1, 1'b0, 1'b1, W2, "R9");
    expect_lookup(PC_C, 1'b0, 1'b0, 1'b0, '0, "R9");
    do_update(PC_B, W2);                               // 1 -> 2 shows counter was not moved
    expect_lookup(PC_B, 1'b1, 1'b1, 1'b1, W2, "R9");
  endtask

  task automatic t_same_cycle();
    // PC_A holds V2 with counter 1
    @(negedge clk);
    upd_en     = 1'b1;
    upd_pc     = PC_A;
    upd_result = V2;
    expect_lookup(PC_A, 1'b1, 1'b0, 1'b1, V2, "R8");  // old state visible
    @(negedge clk);
    upd_en = 1'b0;
    expect_lookup(PC_A, 1'b1, 1'b1, 1'b1, V2, "R8");  // counter now 2
  endtask

  task automatic t_conflict();
    expect_lookup(PC_C, 1'b0, 1'b0, 1'b0, '0, "R10"); // same slot, other tag
    do_update(PC_C, X1);
    expect_lookup(PC_C, 1'b1, 1'b0, 1'b1, X1, "R10");
    expect_lookup(PC_A, 1'b0, 1'b0, 1'b0, '0, "R10");
    expect_lookup(PC_B, 1'b1, 1'b1, 1'b1, W2, "R2");
  endtask

  initial begin
    n_vec      = 0;
    n_bad      = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    upd_en     = 1'b0;
    upd_pc     = '0;
    upd_result = '0;
    lkp_pc     = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_train();
    t_sticky();
    t_floor();
    t_ignore();
    t_same_cycle();
    t_conflict();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule